// File: doc/BRIEF.md
# Vectored Interrupt Entry Controller

This block stands between the interrupt sources of a small processor and its core. It accepts a set of hardware request lines raised by devices and one software trap request raised by an instruction, such as a system call or an error. It remembers every request until that request is serviced. When the core is not already inside a handler, the block picks one pending source by fixed priority and saves the address of the interrupted instruction. It then looks up the handler address for that source in an internal vector table and emits a one-cycle redirect that carries that address. In the same step it forces the privilege bit to kernel.

While a handler runs, all further entries are held off. A return pulse from the core sends the program counter back to the saved address and restores the privilege bit that was in force before entry. It also re-opens entry, so pending sources are then taken one after another. The vector table is filled through a plain write port. A separate input lets the core drop to user mode when it is idle.

Top module: `irq_vector_entry`

## Requirements
- R1: A request pulse on any hardware line or on the trap input is remembered until that source is serviced. A request that arrives while a handler runs is taken after the return and is not lost.
- R2: Cause codes are assigned as follows: the trap is code 0 and hardware line i is code i+1. When several sources are pending, the lowest code is served first.
- R3: Entry happens on the first clock edge at which a source is pending and no handler runs. After that edge, redirect_valid is high for exactly one cycle. During that cycle, redirect_pc equals the vector table entry for the served code, and cause reports that code.
- R4: At the entry edge, epc captures cur_pc and holds it until the next entry.
- R5: After entry, priv_mode is 0 (kernel), and the previous value of priv_mode (1 = user) is kept for the return.
- R6: While in_handler is high, no further entry takes place: cause and epc stay unchanged and redirect_valid stays low until the return.
- R7: A ret_pulse while in_handler is high clears in_handler, gives a one-cycle redirect with redirect_pc equal to epc, and restores priv_mode to its value before entry. A ret_pulse while no handler runs has no effect.
- R8: A cycle with vec_we high writes vec_data into the table entry selected by vec_idx. Later entries for that code use the new value.
- R9: After reset: priv_mode is 0, in_handler and redirect_valid are 0, nothing is pending, and every table entry is 0.
- R10: set_user sets priv_mode to 1 only when no handler runs and no entry happens at that edge. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | NUM_HW | Hardware request pulses, one per line |
| trap_req | input | 1 | Software trap request pulse |
| cur_pc | input | ADDR_W | Address of the instruction that would be interrupted |
| ret_pulse | input | 1 | Return from handler |
| set_user | input | 1 | Request to switch to user mode |
| vec_we | input | 1 | Vector table write enable |
| vec_idx | input | CAUSE_W | Vector table entry to write (cause code) |
| vec_data | input | ADDR_W | Handler address to store |
| redirect_valid | output | 1 | One-cycle program counter redirect |
| redirect_pc | output | ADDR_W | Redirect target |
| cause | output | CAUSE_W | Code of the source being served |
| epc | output | ADDR_W | Saved return address |
| priv_mode | output | 1 | Privilege bit, 0 kernel, 1 user |
| in_handler | output | 1 | A handler is running |

## Verification
The bench builds the block with three hardware lines and a 12-bit address, which gives four sources and a 2-bit cause code. With these values it can sweep all sixteen combinations of simultaneous requests, in both user and kernel mode. For each combination it follows the full chain of entries and returns and checks the service order, the vector targets, the saved addresses and the restored mode. It also injects a request in the middle of a handler, a stray return and a mode switch during a handler. It rewrites a table entry after it has been used and confirms that later entries use the new value.

// File: rtl/irq_vector_entry.sv
module irq_vector_entry #(
  parameter int NUM_HW = 4,
  parameter int ADDR_W = 16,
  localparam int NUM_SRC = NUM_HW + 1,
  localparam int CAUSE_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_HW-1:0]  hw_req,
  input  logic               trap_req,
  input  logic [ADDR_W-1:0]  cur_pc,
  input  logic               ret_pulse,
  input  logic               set_user,
  input  logic               vec_we,
  input  logic [CAUSE_W-1:0] vec_idx,
  input  logic [ADDR_W-1:0]  vec_data,
  output logic               redirect_valid,
  output logic [ADDR_W-1:0]  redirect_pc,
  output logic [CAUSE_W-1:0] cause,
  output logic [ADDR_W-1:0]  epc,
  output logic               priv_mode,
  output logic               in_handler
);

  logic [NUM_SRC-1:0] pend_q, grant;
  logic [CAUSE_W-1:0] sel;
  logic [ADDR_W-1:0]  vec_q [NUM_SRC];
  logic               saved_mode_q;
  logic               enter, leave;

  always_comb begin
    sel = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--)
      if (pend_q[k]) sel = CAUSE_W'(k);
  end

  assign enter = (|pend_q) && !in_handler;
  assign leave = ret_pulse && in_handler;
  assign grant = enter ? (NUM_SRC'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~grant) | {hw_req, trap_req};
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rst_n)                              vec_q[g] <= '0;
      else if (vec_we && vec_idx == CAUSE_W'(g)) vec_q[g] <= vec_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_handler     <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      cause          <= '0;
      epc            <= '0;
      priv_mode      <= 1'b0;
      saved_mode_q   <= 1'b0;
    end else begin
      redirect_valid <= enter || leave;
      if (enter) begin
        in_handler   <= 1'b1;
        redirect_pc  <= vec_q[sel];
        cause        <= sel;
        epc          <= cur_pc;
        saved_mode_q <= priv_mode;
        priv_mode    <= 1'b0;
      end else if (leave) begin
        in_handler   <= 1'b0;
        redirect_pc  <= epc;
        priv_mode    <= saved_mode_q;
      end else if (set_user && !in_handler) begin
        priv_mode    <= 1'b1;
      end
    end
  end

  assert_entry_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_handler) |-> redirect_valid);

  assert_epc_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_handler) |-> epc == $past(cur_pc));

  assert_kernel_in_handler_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler |-> priv_mode == 1'b0);

  assert_no_nesting_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler && !ret_pulse |=> in_handler && !redirect_valid && $stable(cause) && $stable(epc));

  assert_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler && ret_pulse |=> !in_handler && redirect_valid && redirect_pc == $past(epc));

  assert_trap_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_handler) && $past(pend_q[0]) |-> cause == '0);

endmodule

// File: tb/test_irq_vector_entry.sv
module test_irq_vector_entry;
  localparam int NHW = 3;
  localparam int AW  = 12;
  localparam int CW  = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [NHW-1:0] hw_req = '0;
  logic trap_req = 0, ret_pulse = 0, set_user = 0, vec_we = 0;
  logic [AW-1:0] cur_pc = '0, vec_data = '0;
  logic [CW-1:0] vec_idx = '0;
  logic redirect_valid, priv_mode, in_handler;
  logic [AW-1:0] redirect_pc, epc;
  logic [CW-1:0] cause;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vector_entry #(.NUM_HW(NHW), .ADDR_W(AW)) i_irq_vector_entry (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .trap_req(trap_req),
    .cur_pc(cur_pc), .ret_pulse(ret_pulse), .set_user(set_user),
    .vec_we(vec_we), .vec_idx(vec_idx), .vec_data(vec_data),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .cause(cause), .epc(epc), .priv_mode(priv_mode), .in_handler(in_handler));

  function automatic logic [AW-1:0] vexp(int c);
    return AW'(12'h100 + c * 12'h23);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    bit model_mode;
    logic [AW-1:0] entry_pc;
    repeat (3) @(negedge clk);
    chk(in_handler == 0, "R9 in_handler", in_handler, 0);
    chk(redirect_valid == 0, "R9 redirect", redirect_valid, 0);
    chk(priv_mode == 0, "R9 mode", priv_mode, 0);
    rst_n = 1;
    tick;
    chk(redirect_valid == 0, "R9 nothing pending", redirect_valid, 0);

    hw_req = 3'b001; tick; hw_req = '0; tick;
    chk(redirect_valid && redirect_pc == 0, "R9 vector zero", redirect_pc, 0);
    ret_pulse = 1; tick; ret_pulse = 0;
    chk(redirect_valid && redirect_pc == 0 && !in_handler, "R7 first return", redirect_pc, 0);
    tick;

    for (int c = 0; c < 4; c++) begin
      vec_we = 1; vec_idx = CW'(c); vec_data = vexp(c); tick;
    end
    vec_we = 0;

    model_mode = 0;
    for (int m = 0; m < 16; m++) begin
      if (m == 8) begin
        set_user = 1; tick; set_user = 0;
        model_mode = 1;
        chk(priv_mode == 1, "R10 set user", priv_mode, 1);
      end
      cur_pc = AW'(12'h400 + m * 16);
      trap_req = m[0]; hw_req = 3'(m >> 1); tick;
      trap_req = 0; hw_req = '0;
      if (m == 0) begin
        tick; tick;
        chk(!redirect_valid && !in_handler, "R3 no request no entry", redirect_valid, 0);
        ret_pulse = 1; tick; ret_pulse = 0;
        chk(!redirect_valid && priv_mode == model_mode, "R7 stray return ignored", redirect_valid, 0);
        continue;
      end
      for (int c = 0; c < 4; c++) begin
        if (!m[c]) continue;
        cur_pc = cur_pc + 4;
        entry_pc = cur_pc;
        tick;
        chk(redirect_valid && in_handler, "R3 entry pulse", redirect_valid, 1);
        chk(cause == CW'(c), "R2 priority order", cause, c);
        chk(redirect_pc == vexp(c), "R3 vector target", redirect_pc, vexp(c));
        chk(epc == entry_pc, "R4 saved address", epc, entry_pc);
        chk(priv_mode == 0, "R5 kernel on entry", priv_mode, 0);
        cur_pc = cur_pc + 12'h40;
        tick;
        chk(!redirect_valid && in_handler && epc == entry_pc, "R6 masked while busy", redirect_valid, 0);
        ret_pulse = 1; tick; ret_pulse = 0;
        chk(redirect_valid && redirect_pc == entry_pc, "R7 return target", redirect_pc, entry_pc);
        chk(priv_mode == model_mode && !in_handler, "R7 mode restored", priv_mode, model_mode);
      end
      tick;
      chk(!redirect_valid && !in_handler, "R1 all served", redirect_valid, 0);
    end

    cur_pc = 12'h7A0;
    trap_req = 1; tick; trap_req = 0; tick;
    chk(in_handler && cause == 0, "R2 trap entry", cause, 0);
    hw_req = 3'b010; tick; hw_req = '0; tick; tick;
    chk(in_handler && cause == 0 && !redirect_valid, "R6 no nested entry", cause, 0);
    set_user = 1; tick; set_user = 0;
    chk(priv_mode == 0, "R10 set user ignored in handler", priv_mode, 0);
    ret_pulse = 1; tick; ret_pulse = 0;
    chk(redirect_pc == 12'h7A0 && priv_mode == 1, "R7 return after trap", redirect_pc, 12'h7A0);
    tick;
    chk(redirect_valid && cause == 2 && redirect_pc == vexp(2), "R1 late request taken", cause, 2);
    ret_pulse = 1; tick; ret_pulse = 0; tick;

    vec_we = 1; vec_idx = 2'd2; vec_data = 12'h9C4; tick; vec_we = 0;
    hw_req = 3'b010; tick; hw_req = '0; tick;
    chk(redirect_valid && redirect_pc == 12'h9C4, "R8 rewritten vector", redirect_pc, 12'h9C4);
    ret_pulse = 1; tick; ret_pulse = 0; tick;

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule